// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

A purely combinational n-bit datapath stage that merges an adder-based arithmetic path, a four-function bitwise path and a single-place shifter behind one output multiplexer. A two-bit stage select chooses which path drives the result. A two-bit operation select, together with a carry input, picks the operation inside the arithmetic or bitwise path.

The shifter moves the A operand by exactly one place in either direction. The bit that enters at the vacated end comes from a dedicated fill input for each direction, so a caller can build logical shifts (fill with zero) or chain several units. The arithmetic path also produces a carry-out. The carry-out is forced low whenever a non-arithmetic path is selected.

Top module: `alsu_top`

## Requirements
- R1: With stage_sel_i = 2'b00, {carry_o, f_o} = a_i + y + carry_i, where y is chosen by op_sel_i as follows: 2'b00 gives zero, 2'b01 gives b_i, 2'b10 gives ~b_i, and 2'b11 gives all ones. The eight cases are transfer, increment, add, add plus one, subtract with borrow, subtract, decrement and transfer.
- R2: carry_o is 0 whenever stage_sel_i is not 2'b00.
- R3: With stage_sel_i = 2'b01, f_o is chosen by op_sel_i as follows: 2'b00 gives a_i & b_i, 2'b01 gives a_i | b_i, 2'b10 gives a_i ^ b_i, and 2'b11 gives ~a_i. carry_i has no effect.
- R4: With stage_sel_i = 2'b10 (shift right), f_o[i] = a_i[i+1] for i below the top bit, and f_o[WIDTH-1] = fill_hi_i.
- R5: With stage_sel_i = 2'b11 (shift left), f_o[i] = a_i[i-1] for i above 0, and f_o[0] = fill_lo_i.
- R6: In both shift modes, op_sel_i and carry_i have no effect on f_o.
- R7: With both fill inputs at 0, a_i = 8'b11001010 gives 8'b01100101 on a right shift and 8'b10010100 on a left shift.
- R8: fill_hi_i and fill_lo_i have no effect on f_o or carry_o in stages 2'b00 and 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| stage_sel_i | input | 2 | Path select: arithmetic, logic, shift right, shift left |
| op_sel_i | input | 2 | Operation within the arithmetic or logic path |
| carry_i | input | 1 | Carry into the adder |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| fill_hi_i | input | 1 | Bit entering the top position on a right shift |
| fill_lo_i | input | 1 | Bit entering bit 0 on a left shift |
| f_o | output | WIDTH | Result |
| carry_o | output | 1 | Adder carry-out, 0 outside the arithmetic path |

## Verification
The bench applies all eight arithmetic selections to one fixed pair of operands, A = 11001010 and B = 00110101. Each selection then gives a distinct sum and carry, so a swapped y-mux leg or a dropped carry_i is exposed. The operands are chosen so that AND yields zero while OR and XOR yield all ones, and complement yields B. This makes a swapped logic leg visible. Both shifts are applied with each fill value. The cases of all ones plus one, zero minus one and 0x80 + 0x80 probe full carry propagation. The carry input, the operation select and the fill inputs are toggled in modes that must ignore them, and the bench checks that the result does not change.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
  typedef enum logic [1:0] {
    STG_ARITH = 2'b00,
    STG_LOGIC = 2'b01,
    STG_SHR   = 2'b10,
    STG_SHL   = 2'b11
  } stage_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_XOR = 2'b10,
    LOP_NOT = 2'b11
  } logic_op_e;
endpackage

// File: rtl/alsu_arith.sv
module alsu_arith #(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       op_sel_i,
  input  logic             carry_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] d_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] y;
  logic [WIDTH:0]   c;

  assign c[0] = carry_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (op_sel_i)
        2'b00:   y[i] = 1'b0;
        2'b01:   y[i] = b_i[i];
        2'b10:   y[i] = ~b_i[i];
        default: y[i] = 1'b1;
      endcase
    end
    // ripple full adder
    assign d_o[i]   = a_i[i] ^ y[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & y[i]) | (c[i] & (a_i[i] ^ y[i]));
  end

  assign carry_o = c[WIDTH];
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       op_sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] e_o
);
  logic_op_e op;
  assign op = logic_op_e'(op_sel_i);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (op)
        LOP_AND: e_o[i] = a_i[i] & b_i[i];
        LOP_OR:  e_o[i] = a_i[i] | b_i[i];
        LOP_XOR: e_o[i] = a_i[i] ^ b_i[i];
        default: e_o[i] = ~a_i[i];
      endcase
    end
  end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             fill_hi_i,
  input  logic             fill_lo_i,
  output logic [WIDTH-1:0] shr_o,
  output logic [WIDTH-1:0] shl_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      assign shr_o[i] = fill_hi_i;
    end else begin : g_mid_r
      assign shr_o[i] = a_i[i+1];
    end
    if (i == 0) begin : g_bot
      assign shl_o[i] = fill_lo_i;
    end else begin : g_mid_l
      assign shl_o[i] = a_i[i-1];
    end
  end
endmodule

// File: rtl/alsu_top.sv
module alsu_top
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       stage_sel_i,
  input  logic [1:0]       op_sel_i,
  input  logic             carry_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             fill_hi_i,
  input  logic             fill_lo_i,
  output logic [WIDTH-1:0] f_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] d, e, shr, shl;
  logic             arith_c;
  stage_e           stage;

  assign stage = stage_e'(stage_sel_i);

  alsu_arith #(.WIDTH(WIDTH)) u_arith (
    .op_sel_i (op_sel_i),
    .carry_i  (carry_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .d_o      (d),
    .carry_o  (arith_c)
  );

  alsu_logic #(.WIDTH(WIDTH)) u_logic (
    .op_sel_i (op_sel_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .e_o      (e)
  );

  alsu_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i       (a_i),
    .fill_hi_i (fill_hi_i),
    .fill_lo_i (fill_lo_i),
    .shr_o     (shr),
    .shl_o     (shl)
  );

  always_comb begin
    unique case (stage)
      STG_ARITH: f_o = d;
      STG_LOGIC: f_o = e;
      STG_SHR:   f_o = shr;
      default:   f_o = shl;
    endcase
  end

  // carry only meaningful on the arithmetic path
  assign carry_o = (stage == STG_ARITH) ? arith_c : 1'b0;
endmodule

// File: rtl/alsu_chk.sv
module alsu_chk #(
  parameter int WIDTH = 8
) (
  input logic [1:0]       stage_sel_i,
  input logic [1:0]       op_sel_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             fill_hi_i,
  input logic             fill_lo_i,
  input logic [WIDTH-1:0] f_o,
  input logic             carry_o
);
  logic [WIDTH-1:0] y_ref;
  logic [WIDTH:0]   sum_ref;

  always_comb begin
    case (op_sel_i)
      2'b00:   y_ref = '0;
      2'b01:   y_ref = b_i;
      2'b10:   y_ref = ~b_i;
      default: y_ref = '1;
    endcase
    sum_ref = {1'b0, a_i} + {1'b0, y_ref} + {{WIDTH{1'b0}}, carry_i};
  end

  always_comb begin
    // R1
    arith_sum_chk: assert (stage_sel_i != 2'b00 || {carry_o, f_o} == sum_ref);
    // R2
    carry_quiet_chk: assert (stage_sel_i == 2'b00 || carry_o == 1'b0);
    // R3
    logic_not_chk: assert (!(stage_sel_i == 2'b01 && op_sel_i == 2'b11) || f_o == ~a_i);
    // R4
    shr_chk: assert (stage_sel_i != 2'b10 || f_o == {fill_hi_i, a_i[WIDTH-1:1]});
    // R5
    shl_chk: assert (stage_sel_i != 2'b11 || f_o == {a_i[WIDTH-2:0], fill_lo_i});
  end
endmodule

bind alsu_top alsu_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/alsu_top_tb_top.sv
module alsu_top_tb_top;
  localparam int W = 8;

  typedef struct packed {
    logic [1:0]   stg;
    logic [1:0]   op;
    logic         cin;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         fh;
    logic         fl;
    logic [W-1:0] ef;
    logic         ec;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    // R1 arithmetic, A=CA B=35
    '{2'b00, 2'b00, 1'b0, 8'hCA, 8'h35, 1'b0, 1'b0, 8'hCA, 1'b0, 4'd1},
    '{2'b00, 2'b00, 1'b1, 8'hCA, 8'h35, 1'b0, 1'b0, 8'hCB, 1'b0, 4'd1},
    '{2'b00, 2'b01, 1'b0, 8'hCA, 8'h35, 1'b0, 1'b0, 8'hFF, 1'b0, 4'd1},
    '{2'b00, 2'b01, 1'b1, 8'hCA, 8'h35, 1'b0, 1'b0, 8'h00, 1'b1, 4'd1},
    '{2'b00, 2'b10, 1'b0, 8'hCA, 8'h35, 1'b0, 1'b0, 8'h94, 1'b1, 4'd1},
    '{2'b00, 2'b10, 1'b1, 8'hCA, 8'h35, 1'b0, 1'b0, 8'h95, 1'b1, 4'd1},
    '{2'b00, 2'b11, 1'b0, 8'hCA, 8'h35, 1'b0, 1'b0, 8'hC9, 1'b1, 4'd1},
    '{2'b00, 2'b11, 1'b1, 8'hCA, 8'h35, 1'b0, 1'b0, 8'hCA, 1'b1, 4'd1},
    // R1 carry propagation corners
    '{2'b00, 2'b00, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'd1},
    '{2'b00, 2'b11, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b0, 4'd1},
    '{2'b00, 2'b01, 1'b0, 8'h80, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1, 4'd1},
    // R3 logic with carry_i high, R2 carry stays low
    '{2'b01, 2'b00, 1'b1, 8'hCA, 8'h35, 1'b0, 1'b0, 8'h00, 1'b0, 4'd3},
    '{2'b01, 2'b01, 1'b1, 8'hCA, 8'h35, 1'b0, 1'b0, 8'hFF, 1'b0, 4'd3},
    '{2'b01, 2'b10, 1'b1, 8'hCA, 8'h35, 1'b0, 1'b0, 8'hFF, 1'b0, 4'd3},
    '{2'b01, 2'b11, 1'b1, 8'hCA, 8'h35, 1'b0, 1'b0, 8'h35, 1'b0, 4'd3},
    '{2'b01, 2'b00, 1'b0, 8'hF0, 8'h3C, 1'b0, 1'b0, 8'h30, 1'b0, 4'd3},
    // R7 logical shifts of 11001010
    '{2'b10, 2'b00, 1'b0, 8'hCA, 8'h00, 1'b0, 1'b0, 8'h65, 1'b0, 4'd7},
    '{2'b11, 2'b00, 1'b0, 8'hCA, 8'h00, 1'b0, 1'b0, 8'h94, 1'b0, 4'd7},
    // R4 fill high, R6 op and carry toggled
    '{2'b10, 2'b11, 1'b1, 8'hCA, 8'hFF, 1'b1, 1'b0, 8'hE5, 1'b0, 4'd4},
    '{2'b10, 2'b01, 1'b1, 8'h01, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 4'd6},
    // R5 fill low, R6 op and carry toggled
    '{2'b11, 2'b11, 1'b1, 8'hCA, 8'hFF, 1'b0, 1'b1, 8'h95, 1'b0, 4'd5},
    '{2'b11, 2'b10, 1'b1, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd6}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   stage_sel_i = '0;
  logic [1:0]   op_sel_i = '0;
  logic         carry_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         fill_hi_i = 1'b0;
  logic         fill_lo_i = 1'b0;
  logic [W-1:0] f_o;
  logic         carry_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  alsu_top #(.WIDTH(W)) dut_i (
    .stage_sel_i (stage_sel_i),
    .op_sel_i    (op_sel_i),
    .carry_i     (carry_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .fill_hi_i   (fill_hi_i),
    .fill_lo_i   (fill_lo_i),
    .f_o         (f_o),
    .carry_o     (carry_o)
  );

  task automatic apply(input vec_t v);
    @(negedge clk);
    stage_sel_i = v.stg;
    op_sel_i    = v.op;
    carry_i     = v.cin;
    a_i         = v.a;
    b_i         = v.b;
    fill_hi_i   = v.fh;
    fill_lo_i   = v.fl;
    @(posedge clk);
    #1;
  endtask

  task automatic check_val(input string tag, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    vec_t v;
    logic [W-1:0] ref_f;
    logic         ref_c;

    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    // reset state: all inputs zero is transfer of A=0 (R1)
    check_val("R1 reset f", {1'b0, f_o}, '0);
    check_val("R2 reset carry", {{W{1'b0}}, carry_o}, '0);

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k]);
      check_val($sformatf("R%0d vec %0d f", VEC[k].req, k), {1'b0, f_o}, {1'b0, VEC[k].ef});
      check_val($sformatf("R%0d vec %0d carry", VEC[k].req, k),
                {{W{1'b0}}, carry_o}, {{W{1'b0}}, VEC[k].ec});
    end

    // R8: fill inputs must not disturb the arithmetic and logic paths
    v = '{2'b00, 2'b10, 1'b1, 8'hCA, 8'h35, 1'b0, 1'b0, 8'h00, 1'b0, 4'd8};
    apply(v);
    ref_f = f_o;
    ref_c = carry_o;
    v.fh = 1'b1;
    v.fl = 1'b1;
    apply(v);
    check_val("R8 arith f with fills", {1'b0, f_o}, {1'b0, ref_f});
    check_val("R8 arith carry with fills", {{W{1'b0}}, carry_o}, {{W{1'b0}}, ref_c});
    v = '{2'b01, 2'b11, 1'b0, 8'h5A, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 4'd8};
    apply(v);
    check_val("R8 logic f with fills", {1'b0, f_o}, {1'b0, 8'hA5});

    // R2: carry_i high with add that would carry, but shift path selected
    v = '{2'b10, 2'b11, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 4'd2};
    apply(v);
    check_val("R2 shift carry low", {{W{1'b0}}, carry_o}, '0);
    check_val("R4 shr of FF fill0", {1'b0, f_o}, {1'b0, 8'h7F});

    // R6: vary op and carry in left shift, result constant
    for (int o = 0; o < 4; o++) begin
      v = '{2'b11, 2'(o), o[0], 8'hB3, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd6};
      apply(v);
      check_val("R6 shl independent of op/carry", {1'b0, f_o}, {1'b0, 8'h66});
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule